// File: doc/BRIEF.md
# H-Bridge Control and Fault Supervisor

This block is the digital core of a single H-bridge power stage. It converts two logic control inputs into four gate enables: one high-side and one low-side enable for each of the two half-bridges (legs). A static mode input selects how the two inputs are read. In the two-input mode each input steers one output. In the phase/enable mode one input sets the direction and the other gates the bridge. Each leg is driven high (only its high-side enable asserted), driven low (only its low-side enable asserted), or left floating (both enables off).

Every move of a leg into a driven level passes through a dead interval of `DEAD_CYC` cycles with both enables off. A move to floating is immediate. An active-low sleep input forces the bridge off. Leaving sleep starts a wake countdown, and only after it does the bridge follow its inputs.

Three fault flags, already digitised by comparators, are supervised, and each has its own rule:
- Overcurrent must persist longer than a deglitch window before it is confirmed. It then holds the bridge off for a fixed retry lockout, and afterwards the block resumes by itself.
- Undervoltage cuts the bridge at once and releases it only when the flag clears.
- Over-temperature cuts the bridge at once and releases it only when the flag clears.

A three-bit status output reports which fault is active.

State machines:
- **Wake sequencer**, states ASLEEP, WAKING and AWAKE. It moves ASLEEP→WAKING when `sleep_n` is sampled high, and WAKING→AWAKE when the wake count expires. Any state returns to ASLEEP when `sleep_n` is sampled low.
- **Overcurrent supervisor**, states CLEAR, FILTER and LOCKOUT.
  - CLEAR→FILTER when `oc_flag` is high.
  - FILTER→CLEAR when `oc_flag` drops.
  - FILTER→LOCKOUT when the deglitch count expires.
  - LOCKOUT→CLEAR when the retry count expires.
- **Leg sequencer** (one per leg), states OFF, DEAD, HI and LO.
  - OFF→DEAD on a driven target.
  - DEAD→HI or DEAD→LO when the dead count expires.
  - DEAD→OFF, HI→OFF and LO→OFF on a floating target.
  - HI→DEAD and LO→DEAD on a change to the opposite level.

Top module: `hbridge_ctrl`

## Requirements
- R1: With `mode_pe`=0, the steady gate pattern for (`ctl_a`,`ctl_b`) is as follows. 00 gives both legs floating. 01 gives leg0 low and leg1 high. 10 gives leg0 high and leg1 low. 11 gives both legs low.
- R2: With `mode_pe`=1, `ctl_b` is the enable and `ctl_a` is the phase. Enable 0 gives both legs low, whatever the phase. Enable 1 with phase 0 gives leg0 high and leg1 low. Enable 1 with phase 1 gives leg0 low and leg1 high.
- R3: `hs_en[i]` and `ls_en[i]` are never both 1. A leg enters a driven level only after at least `DEAD_CYC` sampled cycles with both enables off. When a target change is sampled at edge e, the new driven level appears after edge e+`DEAD_CYC`, with both enables off from edge e on.
- R4: `sleep_n` sampled low at an edge turns all four enables off after that edge.
- R5: The first edge that samples `sleep_n` high after sleep is counted as edge 1. With a driving command, the first enable rises at edge `WAKE_CYC`+`DEAD_CYC`+2, and all enables stay off before it.
- R6: An `oc_flag` pulse of at most `DEG_CYC` consecutive high samples leaves `fault_stat[0]` at 0 and the outputs unchanged.
- R7: When `oc_flag` is high on `DEG_CYC`+1 consecutive edges, `fault_stat[0]` rises after the last of them, and all enables are off one edge later.
- R8: `fault_stat[0]` stays 1 for exactly `RETRY_CYC` cycles and then the bridge resumes by itself. If `oc_flag` is still high, it is confirmed again after `DEG_CYC`+1 samples and a fresh lockout of `RETRY_CYC` cycles follows.
- R9: `uv_flag` sampled high turns all enables off and sets `fault_stat[1]` after that edge. The bridge resumes only once the flag is low.
- R10: `ot_flag` sampled high turns all enables off and sets `fault_stat[2]` after that edge. The bridge resumes only once every fault has cleared, whatever the order in which they clear.
- R11: In reset, and right after it, all enables are off and `fault_stat` is 0. The wake sequencer starts asleep, so a full wake period is needed even if `sleep_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_pe | input | 1 | Static interface select: 0 two-input, 1 phase/enable |
| ctl_a | input | 1 | Control input 1 (phase in phase/enable mode) |
| ctl_b | input | 1 | Control input 2 (enable in phase/enable mode) |
| sleep_n | input | 1 | Sleep request, active low |
| oc_flag | input | 1 | Overcurrent comparator flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| ot_flag | input | 1 | Over-temperature flag |
| hs_en | output | 2 | High-side gate enable per leg |
| ls_en | output | 2 | Low-side gate enable per leg |
| fault_stat | output | 3 | Active faults: bit0 overcurrent lockout, bit1 undervoltage, bit2 over-temperature |

## Verification
Every row of both interface tables is applied directly. Random input combinations then follow, holding each long enough to settle; these separate the two decodings and show that floating and brake are not confused. A direct forward-to-reverse swap measures the exact dead interval, and a monitor on every cycle catches any leg that drives both switches or skips its all-off gap. Overcurrent pulses of exactly the deglitch length, split pulses, one-longer pulses and a persistent flag tell rejection apart from confirmation and a single retry apart from a restarted lockout. Overlapping undervoltage and over-temperature, cleared one at a time, show that recovery waits for the last fault.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {CMD_Z, CMD_LO, CMD_HI} leg_cmd_t;
    typedef enum logic [1:0] {LEG_OFF, LEG_DEAD, LEG_HI, LEG_LO} leg_state_t;
    typedef enum logic [1:0] {WK_ASLEEP, WK_WAKING, WK_AWAKE} wake_state_t;
    typedef enum logic [1:0] {OC_CLEAR, OC_FILTER, OC_LOCKOUT} oc_state_t;
    localparam int NUM_LEGS = 2;
    localparam int NUM_FAULTS = 3;
endpackage

// File: rtl/hb_decode.sv
module hb_decode
    import hb_pkg::*;
(
    input  logic mode_pe,
    input  logic ctl_a,
    input  logic ctl_b,
    output leg_cmd_t [NUM_LEGS-1:0] cmd
);
    always_comb begin
        cmd = {CMD_Z, CMD_Z};
        if (!mode_pe) begin
            unique case ({ctl_a, ctl_b})
                2'b00: cmd = {CMD_Z,  CMD_Z};
                2'b01: cmd = {CMD_HI, CMD_LO};
                2'b10: cmd = {CMD_LO, CMD_HI};
                2'b11: cmd = {CMD_LO, CMD_LO};
            endcase
        end else begin
            if (!ctl_b)     cmd = {CMD_LO, CMD_LO};
            else if (!ctl_a) cmd = {CMD_LO, CMD_HI};
            else             cmd = {CMD_HI, CMD_LO};
        end
    end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_cmd_t tgt,
    output logic     hs,
    output logic     ls
);
    localparam int DCW = $clog2(DEAD_CYC + 1);
    localparam logic [DCW-1:0] DEAD_LAST = DCW'(DEAD_CYC - 1);

    leg_state_t state, nxt;
    logic [DCW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LEG_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt == LEG_DEAD && state != LEG_DEAD) cnt <= '0;
            else if (state == LEG_DEAD)                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LEG_OFF:  if (tgt != CMD_Z) nxt = LEG_DEAD;
            LEG_DEAD: begin
                if (tgt == CMD_Z)          nxt = LEG_OFF;
                else if (cnt == DEAD_LAST) nxt = (tgt == CMD_HI) ? LEG_HI : LEG_LO;
            end
            LEG_HI:   if (tgt != CMD_HI) nxt = (tgt == CMD_Z) ? LEG_OFF : LEG_DEAD;
            LEG_LO:   if (tgt != CMD_LO) nxt = (tgt == CMD_Z) ? LEG_OFF : LEG_DEAD;
            default:  nxt = LEG_OFF;
        endcase
    end

    always_comb begin
        hs = (state == LEG_HI);
        ls = (state == LEG_LO);
    end

    // R3: never both switches of a leg
    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n) !(hs && ls));
    // R3: a driven level is only entered from the dead state
    p_gap_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs) |-> $past(state) == LEG_DEAD);
    p_gap_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls) |-> $past(state) == LEG_DEAD);
endmodule

// File: rtl/hb_wake.sv
module hb_wake
    import hb_pkg::*;
#(
    parameter int WAKE_CYC = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n,
    output logic awake
);
    localparam int WCW = $clog2(WAKE_CYC + 1);
    localparam logic [WCW-1:0] WAKE_LAST = WCW'(WAKE_CYC - 1);

    wake_state_t state, nxt;
    logic [WCW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WK_ASLEEP;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt == WK_WAKING && state != WK_WAKING) cnt <= '0;
            else if (state == WK_WAKING)                 cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WK_ASLEEP: if (sleep_n) nxt = WK_WAKING;
            WK_WAKING: begin
                if (!sleep_n)              nxt = WK_ASLEEP;
                else if (cnt == WAKE_LAST) nxt = WK_AWAKE;
            end
            WK_AWAKE:  if (!sleep_n) nxt = WK_ASLEEP;
            default:   nxt = WK_ASLEEP;
        endcase
    end

    always_comb awake = (state == WK_AWAKE);

    // R4: a low sleep sample always returns to asleep
    p_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> state == WK_ASLEEP);
    // R5: awake only after the wake countdown
    p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake) |-> $past(state) == WK_WAKING && $past(sleep_n));
endmodule

// File: rtl/hb_fault.sv
module hb_fault
    import hb_pkg::*;
#(
    parameter int DEG_CYC   = 250,
    parameter int RETRY_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic uv_flag,
    input  logic ot_flag,
    output logic oc_lock,
    output logic [NUM_FAULTS-1:0] stat
);
    localparam int GCW = $clog2(DEG_CYC + 1);
    localparam int RCW = $clog2(RETRY_CYC + 1);
    localparam logic [GCW-1:0] DEG_LAST   = GCW'(DEG_CYC - 1);
    localparam logic [RCW-1:0] RETRY_LAST = RCW'(RETRY_CYC - 1);

    oc_state_t state, nxt;
    logic [GCW-1:0] gcnt;
    logic [RCW-1:0] rcnt;
    logic uv_q, ot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OC_CLEAR;
            gcnt  <= '0;
            rcnt  <= '0;
            uv_q  <= 1'b0;
            ot_q  <= 1'b0;
        end else begin
            state <= nxt;
            uv_q  <= uv_flag;
            ot_q  <= ot_flag;
            if (nxt == OC_FILTER && state != OC_FILTER) gcnt <= '0;
            else if (state == OC_FILTER)                gcnt <= gcnt + 1'b1;
            if (nxt == OC_LOCKOUT && state != OC_LOCKOUT) rcnt <= '0;
            else if (state == OC_LOCKOUT)                 rcnt <= rcnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            OC_CLEAR:   if (oc_flag) nxt = OC_FILTER;
            OC_FILTER: begin
                if (!oc_flag)             nxt = OC_CLEAR;
                else if (gcnt == DEG_LAST) nxt = OC_LOCKOUT;
            end
            OC_LOCKOUT: if (rcnt == RETRY_LAST) nxt = OC_CLEAR;
            default:    nxt = OC_CLEAR;
        endcase
    end

    always_comb begin
        oc_lock = (state == OC_LOCKOUT);
        stat    = {ot_q, uv_q, oc_lock};
    end

    // R7: a lockout starts only while the flag is still high
    p_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_lock) |-> $past(oc_flag) && $past(state) == OC_FILTER);
    // R6: a low sample in the filter abandons it
    p_glitch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OC_FILTER && !oc_flag) |=> state == OC_CLEAR);
    // R8: lockout always ends in clear
    p_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oc_lock) |-> state == OC_CLEAR);
    // R9 / R10: status follows the level flags
    p_uv_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> stat[1]);
    p_ot_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> stat[2]);
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int DEAD_CYC  = 3,
    parameter int WAKE_CYC  = 7500,
    parameter int DEG_CYC   = 250,
    parameter int RETRY_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_pe,
    input  logic       ctl_a,
    input  logic       ctl_b,
    input  logic       sleep_n,
    input  logic       oc_flag,
    input  logic       uv_flag,
    input  logic       ot_flag,
    output logic [1:0] hs_en,
    output logic [1:0] ls_en,
    output logic [2:0] fault_stat
);
    leg_cmd_t [NUM_LEGS-1:0] dec_cmd;
    leg_cmd_t [NUM_LEGS-1:0] tgt;
    logic awake, oc_lock, allow;

    hb_decode u_dec (
        .mode_pe (mode_pe),
        .ctl_a   (ctl_a),
        .ctl_b   (ctl_b),
        .cmd     (dec_cmd)
    );

    hb_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_n (sleep_n),
        .awake   (awake)
    );

    hb_fault #(.DEG_CYC(DEG_CYC), .RETRY_CYC(RETRY_CYC)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .oc_flag (oc_flag),
        .uv_flag (uv_flag),
        .ot_flag (ot_flag),
        .oc_lock (oc_lock),
        .stat    (fault_stat)
    );

    always_comb begin
        allow = awake && sleep_n && !uv_flag && !ot_flag && !oc_lock;
        for (int i = 0; i < NUM_LEGS; i++)
            tgt[i] = allow ? dec_cmd[i] : CMD_Z;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .tgt   (tgt[g]),
            .hs    (hs_en[g]),
            .ls    (ls_en[g])
        );
    end

    // R4: sleep removes every gate one edge later
    p_sleep_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> (hs_en == 2'b00 && ls_en == 2'b00));
    // R7: a confirmed overcurrent removes every gate one edge later
    p_oc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stat[0] |=> (hs_en == 2'b00 && ls_en == 2'b00));
    // R9: undervoltage removes every gate one edge later
    p_uv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (hs_en == 2'b00 && ls_en == 2'b00));
    // R10: over-temperature removes every gate one edge later
    p_ot_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> (hs_en == 2'b00 && ls_en == 2'b00));
endmodule

// File: tb/hbridge_ctrl_test.sv
module hbridge_ctrl_test;
    localparam int DT    = 3;
    localparam int WAKE  = 40;
    localparam int DEG   = 8;
    localparam int RETRY = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_pe = 1'b0, ctl_a = 1'b0, ctl_b = 1'b0, sleep_n = 1'b1;
    logic oc_flag = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
    logic [1:0] hs_en, ls_en;
    logic [2:0] fault_stat;

    int checks = 0;
    int fails = 0;
    int shoot_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hbridge_ctrl #(.DEAD_CYC(DT), .WAKE_CYC(WAKE), .DEG_CYC(DEG), .RETRY_CYC(RETRY)) uut (
        .clk(clk), .rst_n(rst_n), .mode_pe(mode_pe), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .sleep_n(sleep_n), .oc_flag(oc_flag), .uv_flag(uv_flag), .ot_flag(ot_flag),
        .hs_en(hs_en), .ls_en(ls_en), .fault_stat(fault_stat)
    );

    // packing {hs1,hs0,ls1,ls0}
    function automatic logic [3:0] exp_gates(input logic m, input logic a, input logic b);
        if (!m) begin
            unique case ({a, b})
                2'b00: return 4'b0000;
                2'b01: return 4'b1001;
                2'b10: return 4'b0110;
                default: return 4'b0011;
            endcase
        end
        if (!b) return 4'b0011;
        if (!a) return 4'b0110;
        return 4'b1001;
    endfunction

    function automatic logic [3:0] gates();
        return {hs_en, ls_en};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic m, input logic a, input logic b);
        @(negedge clk);
        mode_pe = m; ctl_a = a; ctl_b = b;
    endtask

    task automatic count_until_drive(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (gates() == 4'b0000 && n < 1000);
    endtask

    // shoot-through and dead-gap monitor (R3)
    int offcnt [2] = '{100, 100};
    int prevlvl [2] = '{0, 0};
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                int lvl;
                lvl = hs_en[i] ? 2 : (ls_en[i] ? 1 : 0);
                if (hs_en[i] && ls_en[i]) begin
                    shoot_seen++;
                    $display("FAIL R3 shoot-through leg %0d: actual 1 expected 0", i);
                end
                if (lvl != 0 && lvl != prevlvl[i])
                    chk($sformatf("R3 dead gap leg %0d", i), (offcnt[i] >= DT) ? 1 : 0, 1);
                offcnt[i] = (lvl == 0) ? offcnt[i] + 1 : 0;
                prevlvl[i] = lvl;
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        int n, run;
        void'($urandom(32'd20240611));
        // R11 reset state
        cyc(3);
        chk("R11 gates in reset", gates(), 0);
        chk("R11 status in reset", fault_stat, 0);
        @(negedge clk); rst_n = 1'b1; mode_pe = 0; ctl_a = 1; ctl_b = 0;
        cyc(5);
        chk("R11 still asleep after reset", gates(), 0);
        // R5 wake timing
        @(negedge clk); sleep_n = 1'b0;
        cyc(3);
        @(negedge clk); sleep_n = 1'b1;
        count_until_drive(n);
        chk("R5 wake to first drive edges", n, WAKE + DT + 2);
        cyc(DT + 2);
        chk("R5 forward after wake", gates(), exp_gates(0, 1, 0));
        // R1 two-input table
        for (int v = 0; v < 4; v++) begin
            drive(0, v[1], v[0]);
            cyc(DT + 3);
            chk($sformatf("R1 two-input %0d", v), gates(), exp_gates(0, v[1], v[0]));
        end
        // R2 phase/enable table
        for (int v = 0; v < 4; v++) begin
            drive(1, v[1], v[0]);
            cyc(DT + 3);
            chk($sformatf("R2 phase/enable %0d", v), gates(), exp_gates(1, v[1], v[0]));
        end
        // R3 exact dead interval forward -> reverse
        drive(0, 1, 0);
        cyc(DT + 3);
        drive(0, 0, 1);
        cyc(1);
        chk("R3 all off after swap edge", gates(), 0);
        cyc(DT - 1);
        chk("R3 still off at last dead edge", gates(), 0);
        cyc(1);
        chk("R3 reverse after dead time", gates(), exp_gates(0, 0, 1));
        // R4 sleep
        @(negedge clk); sleep_n = 1'b0;
        cyc(1);
        chk("R4 sleep kills gates", gates(), 0);
        cyc(4);
        chk("R4 sleep holds off", gates(), 0);
        @(negedge clk); sleep_n = 1'b1;
        drive(0, 1, 0);
        cyc(WAKE + DT + 6);
        chk("R4 resume after wake", gates(), exp_gates(0, 1, 0));
        // R6 glitch rejection
        @(negedge clk); oc_flag = 1'b1;
        repeat (DEG) @(negedge clk);
        oc_flag = 1'b0;
        cyc(2);
        chk("R6 pulse of DEG ignored status", fault_stat[0], 0);
        chk("R6 pulse of DEG ignored gates", gates(), exp_gates(0, 1, 0));
        @(negedge clk); oc_flag = 1'b1;
        repeat (DEG) @(negedge clk);
        oc_flag = 1'b0;
        @(negedge clk); oc_flag = 1'b1;
        repeat (DEG) @(negedge clk);
        oc_flag = 1'b0;
        cyc(2);
        chk("R6 split pulses ignored", fault_stat[0], 0);
        chk("R6 split pulses gates", gates(), exp_gates(0, 1, 0));
        // R7 confirmation
        @(negedge clk); oc_flag = 1'b1;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!fault_stat[0] && n < 1000);
        chk("R7 confirm after DEG+1 samples", n, DEG + 1);
        chk("R7 gates still on at confirm", gates(), exp_gates(0, 1, 0));
        @(negedge clk); oc_flag = 1'b0;
        @(posedge clk); #1;
        chk("R7 gates off after confirm", gates(), 0);
        // R8 retry length
        run = 2;
        while (fault_stat[0] && run < 100000) begin @(posedge clk); #1; if (fault_stat[0]) run++; end
        chk("R8 lockout length", run, RETRY);
        cyc(DT + 2);
        chk("R8 auto resume", gates(), exp_gates(0, 1, 0));
        // R8 persistent overcurrent restarts lockout
        @(negedge clk); oc_flag = 1'b1;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!fault_stat[0] && n < 1000);
        run = 1;
        while (fault_stat[0] && run < 100000) begin @(posedge clk); #1; if (fault_stat[0]) run++; end
        chk("R8 first lockout length", run, RETRY);
        n = 1;
        while (!fault_stat[0] && n < 1000) begin @(posedge clk); #1; if (!fault_stat[0]) n++; end
        chk("R8 reconfirm gap", n, DEG + 1);
        run = 1;
        while (fault_stat[0] && run < 100000) begin @(posedge clk); #1; if (fault_stat[0]) run++; end
        chk("R8 restarted lockout length", run, RETRY);
        @(negedge clk); oc_flag = 1'b0;
        cyc(DEG + DT + 4);
        chk("R8 running after flag drops", gates(), exp_gates(0, 1, 0));
        // R9 / R10 level faults and recovery order
        @(negedge clk); uv_flag = 1'b1;
        cyc(1);
        chk("R9 uv off", gates(), 0);
        chk("R9 uv status", fault_stat, 3'b010);
        @(negedge clk); ot_flag = 1'b1;
        cyc(3);
        chk("R10 both status", fault_stat, 3'b110);
        @(negedge clk); uv_flag = 1'b0;
        cyc(DT + 4);
        chk("R10 still off while ot", gates(), 0);
        chk("R10 status ot only", fault_stat, 3'b100);
        @(negedge clk); ot_flag = 1'b0;
        cyc(1);
        chk("R10 status clear", fault_stat, 0);
        cyc(DT + 1);
        chk("R10 resume after last fault", gates(), exp_gates(0, 1, 0));
        @(negedge clk); uv_flag = 1'b1;
        @(negedge clk); uv_flag = 1'b0;
        cyc(DT + 3);
        chk("R9 resume after uv clears", gates(), exp_gates(0, 1, 0));
        // random R1 / R2
        for (int k = 0; k < 300; k++) begin
            logic m, a, b;
            m = 1'($urandom()); a = 1'($urandom()); b = 1'($urandom());
            drive(m, a, b);
            cyc(DT + 3);
            chk(m ? "R2 random" : "R1 random", gates(), exp_gates(m, a, b));
        end
        chk("R3 no shoot-through seen", shoot_seen, 0);
        done = 1'b1;
        report();
        $finish;
    end
endmodule